// File: doc/BRIEF.md
# Dual Parity and Word-Compare Unit

The unit holds two separate parity halves. Each half takes eight data bits and one expansion bit, and it raises its flag when an even number of those nine bits are one. A third output reuses the same sixteen data bits as two interleaved 8-bit words and goes high on any bitwise difference between them. Wider parity comes from chaining halves through their expansion inputs. The unit contains a generic chain of this kind that produces one even-parity flag over a vector of `WIDE_N` bits, with the unused positions padded with zero.

The parameter `REG_OUT` selects the output path. At 1, all four outputs sit behind one shared register stage with an asynchronous active-low reset, and they update together one clock after their inputs. At 0, the path is purely combinational.

Top module: `dual_parity_cmp`

## Requirements
- R1: `a_par_o` is 1 when the count of ones in {`a_data_i`, `a_exp_i`} is even, and 0 when it is odd.
- R2: With the data bits held, toggling only a half's expansion bit inverts that half's parity output.
- R3: The halves are independent. `b_data_i`/`b_exp_i` never affect `a_par_o`, and the same holds the other way round. `b_par_o` follows the rule of R1 over {`b_data_i`, `b_exp_i`}.
- R4: Word X takes the even-indexed data bits and word Y the odd-indexed bits. Half a supplies word bits 3:0 (X[i]=a_data_i[2i], Y[i]=a_data_i[2i+1]) and half b supplies bits 7:4. `mismatch_o` is 0 only when X equals Y, and any single unequal pair (bit 2i versus bit 2i+1 of either half) drives it to 1.
- R5: The expansion inputs have no effect on `mismatch_o`.
- R6: `wide_par_o` is 1 when `wide_data_i` holds an even number of ones and 0 otherwise, for any `WIDE_N`.
- R7: With `REG_OUT`=1, all outputs reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R8: While `rst_ni` is low with `REG_OUT`=1, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_data_i | input | 8 | Half a data bits |
| a_exp_i | input | 1 | Half a expansion bit |
| b_data_i | input | 8 | Half b data bits |
| b_exp_i | input | 1 | Half b expansion bit |
| wide_data_i | input | WIDE_N | Vector for the chained parity |
| a_par_o | output | 1 | Half a even-parity flag |
| b_par_o | output | 1 | Half b even-parity flag |
| mismatch_o | output | 1 | Interleaved word mismatch flag |
| wide_par_o | output | 1 | Even-parity flag over wide_data_i |

## Verification
The bench walks one mismatched pair through each of the eight pair positions, so a comparator that paired the wrong bits or dropped half b would miss a position. It pairs matching words with toggled expansion bits, which catches an expansion bit leaking into the compare or a parity that ignores it. Stimulating one half alone exposes crosstalk between the halves. A walking one across the full wide vector catches a cascade whose final polarity is wrong, which would show as every flag inverted. A check just after each input change catches a stage that is transparent or two deep.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int unsigned HALF_W = 8;
  localparam int unsigned OUT_W  = 4;
  typedef struct packed {
    logic wide_par;
    logic mismatch;
    logic b_par;
    logic a_par;
  } dpc_out_t;
endpackage

// File: rtl/parity_half.sv
module parity_half #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         exp_i,
  output logic         even_o
);
  assign even_o = ~^{data_i, exp_i};
endmodule

// File: rtl/word_cmp.sv
module word_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         miss_o
);
  localparam int unsigned PAIRS = W / 2;
  logic [W-1:0] word_x, word_y;

  // half a fills the low word bits, half b the high ones
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign word_x[i]         = a_i[2*i];
    assign word_y[i]         = a_i[2*i+1];
    assign word_x[PAIRS + i] = b_i[2*i];
    assign word_y[PAIRS + i] = b_i[2*i+1];
  end

  assign miss_o = |(word_x ^ word_y);
endmodule

// File: rtl/parity_chain.sv
module parity_chain #(
  parameter int unsigned N = 32,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0] data_i,
  output logic         even_o
);
  localparam int unsigned STAGES = (N + W - 1) / W;
  localparam int unsigned PAD_W  = STAGES * W;
  // each stage flips polarity; odd stage count leaves the even flag intact
  localparam bit          FLIP   = (STAGES % 2) == 0;

  logic [PAD_W-1:0] padded;
  logic [STAGES:0]  link;

  assign padded  = PAD_W'(data_i);
  assign link[0] = 1'b0;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    parity_half #(.W(W)) u_half (
      .data_i (padded[k*W +: W]),
      .exp_i  (link[k]),
      .even_o (link[k+1])
    );
  end

  assign even_o = FLIP ? ~link[STAGES] : link[STAGES];
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned WIDTH = 4,
  parameter bit          REG   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/dual_parity_cmp.sv
module dual_parity_cmp
  import dpc_pkg::*;
#(
  parameter int unsigned WIDE_N  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] a_data_i,
  input  logic              a_exp_i,
  input  logic [HALF_W-1:0] b_data_i,
  input  logic              b_exp_i,
  input  logic [WIDE_N-1:0] wide_data_i,
  output logic              a_par_o,
  output logic              b_par_o,
  output logic              mismatch_o,
  output logic              wide_par_o
);
  dpc_out_t nxt, cur;

  parity_half #(.W(HALF_W)) u_half_a (
    .data_i (a_data_i), .exp_i (a_exp_i), .even_o (nxt.a_par)
  );
  parity_half #(.W(HALF_W)) u_half_b (
    .data_i (b_data_i), .exp_i (b_exp_i), .even_o (nxt.b_par)
  );
  word_cmp #(.W(HALF_W)) u_cmp (
    .a_i (a_data_i), .b_i (b_data_i), .miss_o (nxt.mismatch)
  );
  parity_chain #(.N(WIDE_N), .W(HALF_W)) u_chain (
    .data_i (wide_data_i), .even_o (nxt.wide_par)
  );
  out_stage #(.WIDTH(OUT_W), .REG(REG_OUT)) u_out (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (nxt), .q_o (cur)
  );

  assign a_par_o    = cur.a_par;
  assign b_par_o    = cur.b_par;
  assign mismatch_o = cur.mismatch;
  assign wide_par_o = cur.wide_par;

  if (REG_OUT) begin : g_chk
    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed_q <= 1'b0;
      else         armed_q <= 1'b1;
    end

    assert_exp_flip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && $stable(a_data_i) && (a_exp_i != $past(a_exp_i)))
      |=> (a_par_o != $past(a_par_o)));

    assert_half_indep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && $stable(a_data_i) && $stable(a_exp_i)) |=> $stable(a_par_o));

    assert_pair_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_data_i[0] != a_data_i[1]) |=> mismatch_o);

    assert_pair_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (b_data_i[6] != b_data_i[7]) |=> mismatch_o);

    assert_cmp_no_exp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && $stable(a_data_i) && $stable(b_data_i)) |=> $stable(mismatch_o));

    assert_wide_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && $stable(wide_data_i)) |=> $stable(wide_par_o));
  end
endmodule

// File: tb/tb_dual_parity_cmp.sv
`timescale 1ns/1ps
module tb_dual_parity_cmp;
  localparam int unsigned N = 32;

  typedef struct {
    logic  a_par, b_par, miss, wide;
    string tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   a_d = '0, b_d = '0;
  logic         a_e = 1'b0, b_e = 1'b0;
  logic [N-1:0] w_d = '0;
  logic         a_par, b_par, miss, wide;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  item_t sb[$];
  item_t prev;

  always #2 clk = ~clk;

  dual_parity_cmp #(.WIDE_N(N), .REG_OUT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_data_i(a_d), .a_exp_i(a_e), .b_data_i(b_d), .b_exp_i(b_e),
    .wide_data_i(w_d),
    .a_par_o(a_par), .b_par_o(b_par), .mismatch_o(miss), .wide_par_o(wide)
  );

  task automatic chk(string req, string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s]: actual=%b expected=%b", req, tag, act, exp);
    end
  endtask

  function automatic item_t model(logic [7:0] a, logic ae, logic [7:0] b,
                                  logic be, logic [N-1:0] w, string tag);
    item_t it;
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += a[i];
    it.a_par = ((ones + ae) % 2) == 0;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    it.b_par = ((ones + be) % 2) == 0;
    it.miss = 1'b0;
    for (int i = 0; i < 4; i++)
      if (a[2*i] != a[2*i+1] || b[2*i] != b[2*i+1]) it.miss = 1'b1;
    ones = 0;
    for (int i = 0; i < N; i++) ones += w[i];
    it.wide = (ones % 2) == 0;
    it.tag = tag;
    return it;
  endfunction

  task automatic drive(logic [7:0] a, logic ae, logic [7:0] b, logic be,
                       logic [N-1:0] w, string tag);
    item_t it;
    @(negedge clk);
    a_d = a; a_e = ae; b_d = b; b_e = be; w_d = w;
    it = model(a, ae, b, be, w, tag);
    sb.push_back(it);
    #1;
    // R7: outputs still hold the previous result until the next edge
    chk("R7", tag, a_par, prev.a_par);
    chk("R7", tag, miss, prev.miss);
    chk("R7", tag, wide, prev.wide);
    prev = it;
  endtask

  always @(posedge clk) begin
    item_t it;
    #1;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      chk("R1", it.tag, a_par, it.a_par);
      chk("R3", it.tag, b_par, it.b_par);
      chk("R4", it.tag, miss, it.miss);
      chk("R6", it.tag, wide, it.wide);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset", a_par, 1'b0);
    chk("R8", "reset", b_par, 1'b0);
    chk("R8", "reset", miss, 1'b0);
    chk("R8", "reset", wide, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    prev = model('0, 1'b0, '0, 1'b0, '0, "idle");

    drive(8'h00, 1'b0, 8'h00, 1'b0, '0, "zeros");
    drive(8'hFF, 1'b1, 8'hFF, 1'b1, '1, "ones");
    // R1 and R3: walk a single one through half a with half b idle
    for (int i = 0; i < 8; i++) drive(8'h01 << i, 1'b0, 8'h00, 1'b0, '0, "walk_a");
    for (int i = 0; i < 8; i++) drive(8'h00, 1'b0, 8'h01 << i, 1'b1, '0, "walk_b");
    // R2: expansion bit alone flips parity
    drive(8'h5A, 1'b0, 8'h5A, 1'b0, '0, "exp_base");
    drive(8'h5A, 1'b1, 8'h5A, 1'b0, '0, "exp_a_R2");
    drive(8'h5A, 1'b1, 8'h5A, 1'b1, '0, "exp_b_R2");
    // R4: matching words, then one mismatched pair in each position
    drive(8'hC3, 1'b0, 8'h3C, 1'b0, '0, "match");
    for (int p = 0; p < 8; p++) begin
      logic [7:0] a = 8'hC3, b = 8'h3C;
      if (p < 4) a[2*p] = ~a[2*p];
      else       b[2*(p-4)+1] = ~b[2*(p-4)+1];
      drive(a, 1'b0, b, 1'b0, '0, "pair_R4");
    end
    // R5: expansion bits toggled around matching words
    drive(8'hF0, 1'b1, 8'h0F, 1'b0, '0, "match_exp_R5");
    drive(8'hF0, 1'b0, 8'h0F, 1'b1, '0, "match_exp_R5");
    // R6: walking one and pairs over the wide vector
    for (int i = 0; i < N; i++) drive('0, 1'b0, '0, 1'b0, N'(1) << i, "wide_R6");
    drive('0, 1'b0, '0, 1'b0, N'(3) << (N-2), "wide_top_R6");
    for (int r = 0; r < 400; r++)
      drive(8'($urandom), 1'($urandom), 8'($urandom), 1'($urandom),
            N'($urandom), "random");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule